// File: doc/BRIEF.md
# Receive Cell Buffer Status Controller

This block owns the write side of a circular store of received data cells. Every arriving cell is either taken or dropped, depending on a receive-enable bit. A taken cell gets a write strobe and the current write address, and then the write pointer moves forward. The controller compares that pointer with a read pointer owned by software. From the comparison it raises sticky flags for a half-full store and for an overrun. It also raises flags for each cell arrival and for wrap-around of a running cell counter.

Software reaches the block through a small register port with two registers: a control word and a status word. In the control word, each event has its own service-enable bit. A single service-request output is raised while any flag whose service bit is set is asserted. Software clears a flag by writing zero to its bit. This lets it acknowledge one event without disturbing the others.

Top module: `rxbuf_status_ctl`

## Requirements
- R1: After reset, both registers read 0x0000, the write pointer and cell counter are 0, and the service request is low.
- R2: While control bit 0 (receive enable) is 0, an arriving cell causes no write strobe, sets no flag and does not change the cell counter.
- R3: While enabled, an arriving cell asserts the write strobe in the same cycle, with the write address equal to the current write pointer. The pointer then advances by one modulo 256 at the clock edge.
- R4: Each accepted cell sets status bit 2 (arrival).
- R5: Status bit 1 (overrun) is set when the write pointer after an accepted write equals the read pointer.
- R6: Status bit 3 (half full) is set when an accepted write leaves the occupancy (write pointer minus read pointer, modulo 256) at 128 or more.
- R7: The cell counter increments on each accepted cell. When it wraps from its maximum value to 0, status bit 4 (rollover) is set.
- R8: Writing the status register clears each flag whose written bit is 0 and keeps each flag whose written bit is 1. If a set event and a clearing write reach the same flag in the same cycle, the flag stays set.
- R9: The service request is high exactly when, for at least one position among bits 1 to 4, the status flag and the control bit at that same position are both 1.
- R10: The control register reads back bits 4:0 as written. Bits 15:5 of both registers and status bit 0 always read 0.
- R11: Writing 0 to the receive enable forces the write pointer to 0 at the next edge, and it stays there while the enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the selected register |
| cell_valid | input | 1 | One-cycle pulse per arriving cell |
| rd_ptr | input | 8 | Software-owned read pointer |
| cell_we | output | 1 | Write strobe for an accepted cell |
| wr_ptr | output | 8 | Write pointer, also the write address |
| cell_count | output | CNT_W | Running count of accepted cells |
| srv_req | output | 1 | Summary service request |

## Verification
On every cycle, the assertions check the following. The pointer steps by exactly one on each accepted cell and holds otherwise. A disabled receiver never strobes. The counter lands on zero after a wrap. A set flag stays set unless a clearing write hits it. A raised service request always has an enabled flag behind it. Other properties can only be shown by the bench's scenarios: the exact cycle the overrun and half-full comparisons fire against a moving read pointer, the set-wins collision, pointer wrap past 255, and the read-back of unused bits. The bench drives these scenarios against a behavioural model compared on every clock.

// File: rtl/rxbs_pkg.sv
package rxbs_pkg;
   localparam int REG_W    = 16;
   localparam int NUM_EV   = 4;
   localparam int B_ENABLE = 0;
   localparam int B_OVR    = 1;
   localparam int B_ARR    = 2;
   localparam int B_HALF   = 3;
   localparam int B_ROLL   = 4;

   typedef enum logic {SEL_CTRL = 1'b0, SEL_STAT = 1'b1} reg_sel_e;

   // packed so that ovr sits in bit 0, matching register bit 1 after shift
   typedef struct packed {
      logic roll;
      logic half;
      logic arr;
      logic ovr;
   } ev_t;
endpackage

// File: rtl/rxbs_wr_ptr.sv
module rxbs_wr_ptr #(
   parameter int PTR_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             accept,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic [PTR_W-1:0] wr_ptr,
   output logic             ovr_hit,
   output logic             half_hit
);
   localparam int DEPTH = 1 << PTR_W;
   localparam logic [PTR_W-1:0] HALF = PTR_W'(DEPTH / 2);

   logic [PTR_W-1:0] nxt;
   logic [PTR_W-1:0] occ;

   generate
      if (PTR_W < 2) begin : g_bad_width
         $error("rxbs_wr_ptr: PTR_W must be at least 2");
      end
   endgenerate

   always_comb begin
      nxt      = wr_ptr + 1'b1;
      occ      = nxt - rd_ptr;
      ovr_hit  = accept && (nxt == rd_ptr);
      half_hit = accept && (occ >= HALF);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_ptr <= '0;
      else if (!en)    wr_ptr <= '0;
      else if (accept) wr_ptr <= nxt;
   end

   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && accept) |=> (wr_ptr == PTR_W'($past(wr_ptr) + 1'b1)));
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !accept) |=> $stable(wr_ptr));
   p_disabled_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (wr_ptr == '0));
endmodule

// File: rtl/rxbs_cell_cnt.sv
module rxbs_cell_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   output logic [CNT_W-1:0] count,
   output logic             roll_hit
);
   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("rxbs_cell_cnt: CNT_W must be at least 1");
      end
   endgenerate

   assign roll_hit = accept && (&count);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (accept) count <= count + 1'b1;
   end

   p_wrap_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      roll_hit |=> (count == '0));
   p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !accept |=> $stable(count));
endmodule

// File: rtl/rxbs_flags.sv
module rxbs_flags #(
   parameter int N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         clr_wr,
   input  logic [N-1:0] keep_mask,
   output logic [N-1:0] flags
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               flags[i] <= 1'b0;
            else if (set[i])
               flags[i] <= 1'b1;
            else if (clr_wr && !keep_mask[i])
               flags[i] <= 1'b0;
         end

         p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(clr_wr && !keep_mask[i])) |=> flags[i]);
         p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flags[i]);
      end
   endgenerate
endmodule

// File: rtl/rxbuf_status_ctl.sv
module rxbuf_status_ctl
   import rxbs_pkg::*;
#(
   parameter int PTR_W   = 8,
   parameter int CNT_W   = 8,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [15:0]      reg_wdata,
   output logic [15:0]      reg_rdata,
   input  logic             cell_valid,
   input  logic [PTR_W-1:0] rd_ptr,
   output logic             cell_we,
   output logic [PTR_W-1:0] wr_ptr,
   output logic [CNT_W-1:0] cell_count,
   output logic             srv_req
);
   localparam int FLD_W = NUM_EV + 1;

   logic              en_q;
   logic [NUM_EV-1:0] srv_en_q;
   logic [NUM_EV-1:0] flags;
   ev_t               ev;
   logic              accept;
   logic              ovr_hit, half_hit, roll_hit;
   logic              ctrl_wr, stat_wr;
   logic              srv_any;
   logic              unused_ok;

   assign unused_ok = &{1'b0, reg_wdata[15:FLD_W]};
   assign ctrl_wr   = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
   assign stat_wr   = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT);
   assign accept    = cell_valid && en_q;
   assign cell_we   = accept;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= 1'b0;
         srv_en_q <= '0;
      end else if (ctrl_wr) begin
         en_q     <= reg_wdata[B_ENABLE];
         srv_en_q <= reg_wdata[B_ROLL:B_OVR];
      end
   end

   rxbs_wr_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n), .en(en_q), .accept(accept),
      .rd_ptr(rd_ptr), .wr_ptr(wr_ptr),
      .ovr_hit(ovr_hit), .half_hit(half_hit)
   );

   rxbs_cell_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .accept(accept),
      .count(cell_count), .roll_hit(roll_hit)
   );

   always_comb begin
      ev.ovr  = ovr_hit;
      ev.arr  = accept;
      ev.half = half_hit;
      ev.roll = roll_hit;
   end

   rxbs_flags #(.N(NUM_EV)) u_flags (
      .clk(clk), .rst_n(rst_n), .set(ev), .clr_wr(stat_wr),
      .keep_mask(reg_wdata[B_ROLL:B_OVR]), .flags(flags)
   );

   always_comb begin
      reg_rdata = '0;
      if (reg_sel_e'(reg_sel) == SEL_STAT)
         reg_rdata[B_ROLL:B_OVR] = flags;
      else begin
         reg_rdata[B_ENABLE]     = en_q;
         reg_rdata[B_ROLL:B_OVR] = srv_en_q;
      end
   end

   assign srv_any = |(flags & srv_en_q);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) srv_req <= 1'b0;
            else        srv_req <= srv_any;
         end
      end else begin : g_irq_comb
         assign srv_req = srv_any;
      end
   endgenerate

   p_no_strobe_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |-> !cell_we);
   p_srv_backed_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (srv_req && !IRQ_REG) |-> (|(flags & srv_en_q)));
   p_stat_low_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
      reg_sel |-> (reg_rdata[15:FLD_W] == '0 && !reg_rdata[0]));
   p_arrival_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cell_we |=> flags[B_ARR-1]);
endmodule

// File: tb/rxbuf_status_ctl_test.sv
module rxbuf_status_ctl_test;
   localparam int CW = 4;
   localparam int CMAX = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic          reg_sel = 1'b0;
   logic [15:0]   reg_wdata = '0;
   logic [15:0]   reg_rdata;
   logic          cell_valid = 1'b0;
   logic [7:0]    rd_ptr = '0;
   logic          cell_we;
   logic [7:0]    wr_ptr;
   logic [CW-1:0] cell_count;
   logic          srv_req;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // behavioural reference state
   int m_ctrl = 0, m_stat = 0, m_wp = 0, m_cnt = 0;

   rxbuf_status_ctl #(.PTR_W(8), .CNT_W(CW), .IRQ_REG(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cell_valid(cell_valid),
      .rd_ptr(rd_ptr), .cell_we(cell_we), .wr_ptr(wr_ptr),
      .cell_count(cell_count), .srv_req(srv_req)
   );

   always #2.5 clk = ~clk;

   task automatic chk(string tag, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
      end
   endtask

   // one clock: drive, compare, advance model
   task automatic step(string tag, bit wr, bit sel, int wd, bit cv);
      int rdx, acc, nxt, sets;
      reg_wr = wr; reg_sel = sel; reg_wdata = 16'(wd); cell_valid = cv;
      #1;
      acc = (cv && (m_ctrl & 1)) ? 1 : 0;
      rdx = sel ? m_stat : m_ctrl;
      chk(tag, "rdata", int'(reg_rdata), rdx);
      chk(tag, "cell_we", int'(cell_we), acc);
      chk(tag, "wr_ptr", int'(wr_ptr), m_wp);
      chk(tag, "count", int'(cell_count), m_cnt);
      chk(tag, "srv", int'(srv_req), ((m_stat & m_ctrl & 'h1E) != 0) ? 1 : 0);
      @(posedge clk);
      sets = 0;
      if (acc != 0) begin
         nxt = (m_wp + 1) % 256;
         sets |= 'h04;
         if (nxt == int'(rd_ptr)) sets |= 'h02;
         if (((nxt - int'(rd_ptr) + 256) % 256) >= 128) sets |= 'h08;
         if (m_cnt == CMAX) sets |= 'h10;
      end
      if (wr && sel) m_stat = m_stat & wd & 'h1E;
      m_stat |= sets;
      if ((m_ctrl & 1) == 0) m_wp = 0;
      else if (acc != 0) m_wp = (m_wp + 1) % 256;
      if (acc != 0) m_cnt = (m_cnt + 1) % (CMAX + 1);
      if (wr && !sel) m_ctrl = wd & 'h1F;
      @(negedge clk);
   endtask

   task automatic cells(string tag, int n);
      for (int i = 0; i < n; i++) step(tag, 0, 1, 0, 1);
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state, both registers
      step("R1", 0, 0, 0, 0);
      step("R1", 0, 1, 0, 0);
      // R2: cells while disabled are dropped
      cells("R2", 5);
      // R10: control read-back masks unused bits
      step("R10", 1, 0, 'hFFFF, 0);
      step("R10", 0, 0, 0, 0);
      // R3 R4 R7: accept with far read pointer, counter wraps at 16
      rd_ptr = 8'd200;
      cells("R3", 3);
      cells("R7", 17);
      step("R10", 0, 1, 0, 0);
      // R8: clearing write collides with arrival, set wins
      step("R8", 1, 1, 'h0000, 1);
      step("R8", 0, 1, 0, 0);
      // R8: write 1 keeps, write 0 clears arrival only
      step("R8", 1, 1, 'hFFFB, 0);
      step("R8", 0, 1, 0, 0);
      step("R8", 1, 1, 'h0000, 0);
      // R9: flags set but services masked
      step("R9", 1, 0, 'h0001, 0);
      rd_ptr = 8'd20;
      cells("R6", 140);
      step("R9", 0, 1, 0, 0);
      step("R9", 1, 0, 'h0009, 0);
      step("R9", 0, 1, 0, 0);
      // R5: read pointer just ahead of writer
      step("R5", 1, 1, 'h0000, 0);
      rd_ptr = 8'(m_wp + 2);
      cells("R5", 3);
      step("R5", 1, 0, 'h0003, 0);
      step("R5", 0, 1, 0, 0);
      // R3: write pointer wraps past 255
      rd_ptr = 8'd0;
      cells("R3", 110);
      // R11: disable resets pointer and drops cells
      step("R11", 1, 0, 'h0000, 0);
      step("R11", 0, 0, 0, 0);
      cells("R2", 4);
      step("R10", 1, 1, 'hFFFF, 0);
      step("R10", 0, 1, 0, 0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule